// File: doc/BRIEF.md
# Programmable Serial Synthesizer Loader

This block loads control words into as many as three external frequency synthesizers over a three-wire style serial link. It drives one data line, one serial clock and one latch strobe per synthesizer. A controlling agent presents a word of up to 32 bits and several settings as plain parallel inputs: how many bits to send, how long the clock's asserted (mark) and idle (space) phases last, which level the clock idles at, the bit order, and which latch strobes to fire. A single-cycle start pulse then begins the transfer.

The engine takes a private copy of every setting when it accepts a start. It then emits the bits, each framed by a space phase and a mark phase that a phase counter times against the programmed limits. After a trailing space it can pulse the selected latch strobes. When it is finished it raises its ready output again. A word wider than one cycle can carry is split by the controller over several transfers, and only the final transfer selects a latch strobe. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies. A start that arrives while the engine is busy is dropped and causes no back-pressure.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset, `ready_o` is 1, `sclk_o` is 0, `sdata_o` is 0 and `le_o` is 3'b000.
- R2: `start_i` is taken only while `ready_o` is 1, and `ready_o` is 0 from the next clock edge until the transfer completes.
- R3: A transfer emits exactly `nbits_i` clock pulses, one data bit per pulse. A count of 0 emits no pulses; the trailing space and the optional latch pulse still take place.
- R4: With `lsb_first_i`=0 the bits go out as `word_i[nbits_i-1]` down to `word_i[0]`. With `lsb_first_i`=1 they go out as `word_i[0]` up to `word_i[nbits_i-1]`. Bits at or above `nbits_i` are never sent.
- R5: Every mark phase lasts `mark_len_i`+1 clock cycles. Every space phase lasts `space_len_i`+1 cycles. This covers the space before each bit and the trailing space after the last bit, so a transfer has `nbits_i`+1 space phases.
- R6: With `clk_pol_i`=0 the serial clock idles low and pulses high. With `clk_pol_i`=1 it idles high and pulses low. `sdata_o` changes only while the clock is idle and holds steady through each mark.
- R7: After the trailing space, the engine asserts `le_o[k]` for every set bit k of `le_sel_i`, together and for `mark_len_i`+1 cycles, while the serial clock stays idle. Lines whose select bit is 0 stay low.
- R8: `ready_o` returns to 1 on the clock edge that ends the latch pulse, or on the edge that ends the trailing space when `le_sel_i` is 0.
- R9: A start while busy is ignored, and setting inputs that change after the accepting edge do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a transfer |
| word_i | input | 32 | Word whose low `nbits_i` bits are shifted out |
| nbits_i | input | 5 | Number of data bits (0..31) |
| mark_len_i | input | 5 | Mark phase length minus one, in clock cycles |
| space_len_i | input | 5 | Space phase length minus one, in clock cycles |
| clk_pol_i | input | 1 | Idle level of the serial clock |
| lsb_first_i | input | 1 | 1 sends bit 0 first, 0 sends the top counted bit first |
| le_sel_i | input | 3 | Latch strobe select, one bit per synthesizer |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |
| le_o | output | 3 | Latch strobes |
| ready_o | output | 1 | Engine idle and able to accept a start |

## Verification
The bench classifies every cycle as space, mark, latch or ready, and measures each run of cycles against the programmed lengths. An off-by-one in the phase compare shows up as a run that is one cycle short or long. A missing trailing space shows up as a latch strobe that begins with too few idle cycles before it. A swapped bit index shows up as a reversed or shifted captured word, and this is exercised in both orders and at the 31-bit maximum. Zero-bit transfers, transfers without a latch, inverted polarity, and a second start with altered inputs during a busy transfer target engines that hang, strobe without cause, idle at the wrong level, or restart mid-word.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SPACE = 3'd1,
    ST_MARK  = 3'd2,
    ST_TAIL  = 3'd3,
    ST_LATCH = 3'd4
  } sl_state_e;
endpackage

// File: rtl/sl_phase_timer.sv
module sl_phase_timer #(
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TIME_W-1:0] limit,
  output logic              expired
);
  logic [TIME_W-1:0] cnt_q;

  assign expired = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || expired)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + TIME_W'(1);
  end

  // Phase counter never passes the active limit (R5)
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/sl_bit_pick.sv
module sl_bit_pick #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  nbits,
  input  logic [IDX_W-1:0]  idx,
  input  logic              lsb_first,
  output logic              bit_o
);
  logic [IDX_W-1:0] pos;

  always_comb begin
    if (lsb_first) pos = idx;
    else           pos = nbits - idx - IDX_W'(1);
    bit_o = word[pos];
  end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 5,
  parameter int NUM_LE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [4:0]        nbits_i,
  input  logic [TIME_W-1:0] mark_len_i,
  input  logic [TIME_W-1:0] space_len_i,
  input  logic              clk_pol_i,
  input  logic              lsb_first_i,
  input  logic [NUM_LE-1:0] le_sel_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic [NUM_LE-1:0] le_o,
  output logic              ready_o
);
  import sl_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  sl_state_e         state_q;
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  nbits_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TIME_W-1:0] mark_q;
  logic [TIME_W-1:0] space_q;
  logic              pol_q;
  logic              lsb_q;
  logic [NUM_LE-1:0] sel_q;

  logic              run;
  logic              phase_end;
  logic [TIME_W-1:0] limit;
  logic              cur_bit;
  logic              in_bit;

  assign run     = (state_q != ST_IDLE);
  assign limit   = (state_q == ST_MARK || state_q == ST_LATCH) ? mark_q : space_q;
  assign in_bit  = (state_q == ST_SPACE) || (state_q == ST_MARK);
  assign ready_o = (state_q == ST_IDLE);
  assign sclk_o  = (state_q == ST_MARK) ^ pol_q;
  assign sdata_o = in_bit & cur_bit;

  sl_phase_timer #(.TIME_W(TIME_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .limit   (limit),
    .expired (phase_end)
  );

  sl_bit_pick #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pick (
    .word      (word_q),
    .nbits     (nbits_q),
    .idx       (idx_q),
    .lsb_first (lsb_q),
    .bit_o     (cur_bit)
  );

  for (genvar g = 0; g < NUM_LE; g++) begin : g_le
    assign le_o[g] = (state_q == ST_LATCH) & sel_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      nbits_q <= '0;
      idx_q   <= '0;
      mark_q  <= '0;
      space_q <= '0;
      pol_q   <= 1'b0;
      lsb_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          word_q  <= word_i;
          nbits_q <= IDX_W'(nbits_i);
          mark_q  <= mark_len_i;
          space_q <= space_len_i;
          pol_q   <= clk_pol_i;
          lsb_q   <= lsb_first_i;
          sel_q   <= le_sel_i;
          idx_q   <= '0;
          state_q <= (nbits_i == '0) ? ST_TAIL : ST_SPACE;
        end
        ST_SPACE: if (phase_end) state_q <= ST_MARK;
        ST_MARK: if (phase_end) begin
          if (idx_q == nbits_q - IDX_W'(1)) begin
            state_q <= ST_TAIL;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_SPACE;
          end
        end
        ST_TAIL: if (phase_end) state_q <= (sel_q != '0) ? ST_LATCH : ST_IDLE;
        ST_LATCH: if (phase_end) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Accepted start makes the engine busy on the next edge (R2)
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> !ready_o);

  // Start while busy leaves the captured word alone (R9)
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ready_o) |=> $stable(word_q));

  // Data holds through a mark (R6)
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MARK && $past(state_q == ST_MARK)) |-> $stable(sdata_o));

  // Latch strobes only with the serial clock idle (R7)
  p_latch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (le_o != '0) |-> (sclk_o == pol_q));
endmodule

// File: tb/tb_synth_serial_loader.sv
module tb_synth_serial_loader;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [4:0]  nbits_i = '0;
  logic [4:0]  mark_len_i = '0;
  logic [4:0]  space_len_i = '0;
  logic        clk_pol_i = 1'b0;
  logic        lsb_first_i = 1'b0;
  logic [2:0]  le_sel_i = '0;
  logic        sdata_o, sclk_o, ready_o;
  logic [2:0]  le_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_serial_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .nbits_i(nbits_i), .mark_len_i(mark_len_i), .space_len_i(space_len_i),
    .clk_pol_i(clk_pol_i), .lsb_first_i(lsb_first_i), .le_sel_i(le_sel_i),
    .sdata_o(sdata_o), .sclk_o(sclk_o), .le_o(le_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
    chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    chk(sdata_o == 1'b0, "R1 sdata", sdata_o, 0);
    chk(le_o == 3'b000, "R1 le", le_o, 0);
  endtask

  // Drives one transfer and checks every phase it produces.
  task automatic run_xfer(input logic [31:0] w, input int nb, input int m, input int s,
                          input bit pol, input bit lsb, input logic [2:0] sel, input bit inject);
    int kind, prev, run, idle_runs, latches, n, last_kind;
    bit act, done, prev_sd;
    logic [31:0] cap, expw;
    prev = -1; run = 0; idle_runs = 0; latches = 0; n = 0; last_kind = -1;
    done = 0; prev_sd = 0; cap = '0; expw = '0;
    @(negedge clk);
    word_i = w; nbits_i = 5'(nb); mark_len_i = 5'(m); space_len_i = 5'(s);
    clk_pol_i = pol; lsb_first_i = lsb; le_sel_i = sel; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      word_i = ~w; nbits_i = 5'd3; mark_len_i = 5'd0; space_len_i = 5'd0;
      clk_pol_i = ~pol; lsb_first_i = ~lsb; le_sel_i = ~sel;
    end
    for (int i = 0; i < 4000; i++) begin
      if (i > 0) @(negedge clk);
      start_i = (inject && i == 4);
      act  = (sclk_o != pol);
      kind = ready_o ? 3 : (le_o != 3'b000) ? 2 : act ? 1 : 0;
      if (i == 0) chk(kind != 3, "R2 busy after start", ready_o, 0);
      if (kind == 2) begin
        chk(!act, "R7 clock idle during latch", sclk_o, pol);
        chk(le_o == sel, "R7 strobe lines", le_o, sel);
      end
      if (kind == 1 && prev == 1) chk(sdata_o == prev_sd, "R6 data steady in mark", sdata_o, prev_sd);
      if (kind != prev) begin
        if (prev == 0) begin chk(run == s + 1, "R5 space length", run, s + 1); idle_runs++; end
        if (prev == 1) chk(run == m + 1, "R5 mark length", run, m + 1);
        if (prev == 2) begin chk(run == m + 1, "R7 latch length", run, m + 1); latches++; end
        if (kind == 1 && n < 32) begin cap[n] = sdata_o; n++; end
        if (kind == 3) last_kind = prev;
        run = 1;
      end else begin
        run++;
      end
      prev = kind;
      prev_sd = sdata_o;
      if (kind == 3) begin done = 1; break; end
    end
    chk(done, "R8 transfer completes", done, 1);
    if (!done) return;
    for (int k = 0; k < nb; k++) expw[k] = lsb ? w[k] : w[nb - 1 - k];
    chk(n == nb, "R3 pulse count", n, nb);
    chk(cap == expw, "R4 bit order", cap, expw);
    chk(idle_runs == nb + 1, "R5 space phases", idle_runs, nb + 1);
    chk(latches == ((sel != 0) ? 1 : 0), "R7 latch count", latches, (sel != 0) ? 1 : 0);
    chk(last_kind == ((sel != 0) ? 2 : 0), "R8 ready follows end", last_kind, (sel != 0) ? 2 : 0);
    chk(sclk_o == pol, "R6 idle level", sclk_o, pol);
    chk(le_o == 3'b000, "R7 strobes low when ready", le_o, 0);
  endtask

  task automatic t_msb_first();  run_xfer(32'h0000_0A5C, 12, 2, 1, 1'b0, 1'b0, 3'b001, 1'b0); endtask
  task automatic t_lsb_max();    run_xfer(32'h5A3C_96E1, 31, 0, 0, 1'b1, 1'b1, 3'b100, 1'b0); endtask
  task automatic t_no_latch();   run_xfer(32'hFFFF_FF16, 5, 1, 3, 1'b0, 1'b0, 3'b000, 1'b0); endtask
  task automatic t_zero_bits();  run_xfer(32'hDEAD_BEEF, 0, 3, 2, 1'b0, 1'b1, 3'b010, 1'b0); endtask
  task automatic t_busy_start(); run_xfer(32'h0000_1234, 13, 1, 2, 1'b1, 1'b0, 3'b101, 1'b1); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msb_first();
    t_lsb_max();
    t_no_latch();
    t_zero_bits();
    t_busy_start();
    t_msb_first();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule